// File: doc/BRIEF.md
# Branch and Jump Next-Address Unit

This block works out where a 32-bit processor fetches next after a control-flow instruction. Each cycle it takes the current program counter, the instruction word and the two source register values already read for that instruction. It decodes the instruction and returns the following results:

- the next program counter;
- a flag that says whether control left the sequential path;
- a request to write a return address into a register;
- a flag for a register-held target that is not word aligned.

The block handles three families. Relative branches test one register against zero or two registers against each other. Direct jumps carry a 26-bit word index inside the current 256 MiB region. Register jumps take the whole address from a source register. Each family has a form that saves the address of the next sequential instruction. There is no delay slot, so the return address is the current address plus four.

All results are registered. Each set of outputs appears one clock after the inputs that produced it.

Top module: `bnu_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset, `next_pc` equals parameter `RESET_PC` (default 0). `taken`, `link_we`, `misalign` and `link_reg` are all zero.
- R2: Instruction fields are: opcode = `instr[31:26]`, first source = `instr[25:21]`, second source or sub-code = `instr[20:16]`, destination = `instr[15:11]`, function = `instr[5:0]`, offset = `instr[15:0]`, jump index = `instr[25:0]`. An instruction that none of the later requirements decodes gives `next_pc = pc+4`, with `taken`, `link_we` and `misalign` low. This includes opcode 1 with a sub-code other than 0, 1, 16 or 17.
- R3: Opcode 4 branches when `rs_val == rt_val`. Opcode 5 branches when they differ. A taken branch goes to `pc + 4 + (sign-extended offset << 2)`. An untaken branch goes to `pc+4`.
- R4: Zero tests treat `rs_val` as signed and ignore `rt_val`. Opcode 6 branches when `rs_val <= 0`. Opcode 7 branches when `rs_val > 0`. Opcode 1 with sub-code 0 branches when `rs_val < 0`. Opcode 1 with sub-code 1 branches when `rs_val >= 0`. The target is the one from R3.
- R5: Opcode 1 with sub-code 16 branches when `rs_val < 0`. Sub-code 17 branches when `rs_val >= 0`. Both always raise `link_we` with `link_reg = 31` and `link_data = pc+4`, whether or not the branch is taken.
- R6: Opcodes 2 and 3 jump to `{(pc+4)[31:28], index, 2'b00}` with `taken` high. Opcode 3 also links `pc+4` into register 31.
- R7: Opcode 0 with function 8 jumps to `rs_val`. Function 9 jumps to `rs_val` and links `pc+4` into the register named by the destination field.
- R8: For a register jump whose `rs_val[1:0]` is not zero, `misalign` is high, `taken` is low, `next_pc = pc+4`, and no link is requested.
- R9: Outputs change only on the rising clock edge. They reflect the inputs present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Control left the sequential path |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Register index to receive the return address |
| link_data | output | 32 | Return address, `pc+4` |
| misalign | output | 1 | Register jump target was not word aligned |

## Verification
The assertions assume that `pc` is always word aligned. This matters because the alignment of `next_pc` is only checked for aligned inputs. The assertions also assume that the inputs captured at one edge are those reported at the next edge, so they compare outputs with the sampled past of `pc`. The bench only generates multiples of four for `pc`. It forces `rs_val` to land on every low-bit pattern so that register jumps hit both the aligned and the misaligned cases. It makes equal, zero and negative register values common so that every comparison sees both outcomes.

// File: rtl/bnu_pkg.sv
package bnu_pkg;

   localparam int OPC_W = 6;
   localparam int FN_W  = 6;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
   localparam logic [OPC_W-1:0] OPC_ZTEST   = 6'd1;
   localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JMPL    = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
   localparam logic [OPC_W-1:0] OPC_BLEZ    = 6'd6;
   localparam logic [OPC_W-1:0] OPC_BGTZ    = 6'd7;

   localparam logic [FN_W-1:0]  FN_JREG     = 6'd8;
   localparam logic [FN_W-1:0]  FN_JREGL    = 6'd9;

   localparam logic [4:0] SUB_LTZ  = 5'd0;
   localparam logic [4:0] SUB_GEZ  = 5'd1;
   localparam logic [4:0] SUB_LTZL = 5'd16;
   localparam logic [4:0] SUB_GEZL = 5'd17;

   typedef enum logic [1:0] {
      K_SEQ  = 2'd0,
      K_REL  = 2'd1,
      K_ABS  = 2'd2,
      K_REG  = 2'd3
   } flow_kind_e;

   typedef enum logic [2:0] {
      C_EQ  = 3'd0,
      C_NE  = 3'd1,
      C_LEZ = 3'd2,
      C_GTZ = 3'd3,
      C_LTZ = 3'd4,
      C_GEZ = 3'd5
   } cond_e;

   typedef struct packed {
      flow_kind_e kind;
      cond_e      cond;
      logic       link;
      logic       link_rd;
   } flow_dec_t;

endpackage

// File: rtl/bnu_decode.sv
module bnu_decode
   import bnu_pkg::*;
#(
   parameter int IW = 32
) (
   input  logic [IW-1:0] instr,
   output flow_dec_t     dec
);
   localparam int OPC_LO = IW - OPC_W;

   logic [OPC_W-1:0] opc;
   logic [4:0]       sub;
   logic [FN_W-1:0]  fn;

   assign opc = instr[IW-1:OPC_LO];
   assign sub = instr[20:16];
   assign fn  = instr[FN_W-1:0];

   always_comb begin
      dec.kind    = K_SEQ;
      dec.cond    = C_EQ;
      dec.link    = 1'b0;
      dec.link_rd = 1'b0;
      unique case (opc)
         OPC_SPECIAL: begin
            if (fn == FN_JREG) begin
               dec.kind = K_REG;
            end else if (fn == FN_JREGL) begin
               dec.kind    = K_REG;
               dec.link    = 1'b1;
               dec.link_rd = 1'b1;
            end
         end
         OPC_ZTEST: begin
            unique case (sub)
               SUB_LTZ:  begin dec.kind = K_REL; dec.cond = C_LTZ; end
               SUB_GEZ:  begin dec.kind = K_REL; dec.cond = C_GEZ; end
               SUB_LTZL: begin dec.kind = K_REL; dec.cond = C_LTZ; dec.link = 1'b1; end
               SUB_GEZL: begin dec.kind = K_REL; dec.cond = C_GEZ; dec.link = 1'b1; end
               default:  dec.kind = K_SEQ;
            endcase
         end
         OPC_JMP:  dec.kind = K_ABS;
         OPC_JMPL: begin dec.kind = K_ABS; dec.link = 1'b1; end
         OPC_BEQ:  begin dec.kind = K_REL; dec.cond = C_EQ;  end
         OPC_BNE:  begin dec.kind = K_REL; dec.cond = C_NE;  end
         OPC_BLEZ: begin dec.kind = K_REL; dec.cond = C_LEZ; end
         OPC_BGTZ: begin dec.kind = K_REL; dec.cond = C_GTZ; end
         default:  dec.kind = K_SEQ;
      endcase
   end
endmodule

// File: rtl/bnu_cond.sv
module bnu_cond
   import bnu_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CMP_STYLE = 0
) (
   input  cond_e           cond,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            hit
);
   logic neg, zero, eq;

   assign eq = (a == b);

   generate
      if (CMP_STYLE == 0) begin : g_signbit
         assign neg  = a[XLEN-1];
         assign zero = ~|a;
      end else begin : g_signed
         assign neg  = $signed(a) < $signed({XLEN{1'b0}});
         assign zero = (a == {XLEN{1'b0}});
      end
   endgenerate

   always_comb begin
      unique case (cond)
         C_EQ:    hit = eq;
         C_NE:    hit = ~eq;
         C_LEZ:   hit = neg | zero;
         C_GTZ:   hit = ~neg & ~zero;
         C_LTZ:   hit = neg;
         C_GEZ:   hit = ~neg;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/bnu_target.sv
module bnu_target #(
   parameter int XLEN   = 32,
   parameter int OFF_W  = 16,
   parameter int IDX_W  = 26
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] instr,
   output logic [XLEN-1:0] seq_pc,
   output logic [XLEN-1:0] rel_pc,
   output logic [XLEN-1:0] abs_pc
);
   localparam int EXT_W    = XLEN - OFF_W - 2;
   localparam int REGION_W = XLEN - IDX_W - 2;

   logic [OFF_W-1:0] off;
   logic [XLEN-1:0]  off_bytes;

   assign off       = instr[OFF_W-1:0];
   assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
   assign seq_pc    = pc + XLEN'(4);
   assign rel_pc    = seq_pc + off_bytes;
   assign abs_pc    = {seq_pc[XLEN-1 -: REGION_W], instr[IDX_W-1:0], 2'b00};
endmodule

// File: rtl/bnu_top.sv
module bnu_top
   import bnu_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              RIDX_W    = 5,
   parameter int              OFF_W     = 16,
   parameter int              IDX_W     = 26,
   parameter int              CMP_STYLE = 0,
   parameter bit              LINK_EN   = 1'b1,
   parameter logic [31:0]     RESET_PC  = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   instr,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [XLEN-1:0]   rt_val,
   output logic [XLEN-1:0]   next_pc,
   output logic              taken,
   output logic              link_we,
   output logic [RIDX_W-1:0] link_reg,
   output logic [XLEN-1:0]   link_data,
   output logic              misalign
);
   localparam logic [RIDX_W-1:0] RA_IDX = {RIDX_W{1'b1}};

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("bnu_top: XLEN must be 32");
      end
      if (RIDX_W != 5) begin : g_bad_ridx
         $error("bnu_top: RIDX_W must be 5");
      end
      if (OFF_W + 2 > XLEN || IDX_W + 2 > XLEN) begin : g_bad_fields
         $error("bnu_top: immediate fields exceed XLEN");
      end
   endgenerate

   flow_dec_t       dec;
   logic            cond_hit;
   logic [XLEN-1:0] seq_pc, rel_pc, abs_pc;

   bnu_decode #(.IW(XLEN)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   bnu_cond #(.XLEN(XLEN), .CMP_STYLE(CMP_STYLE)) u_cond (
      .cond (dec.cond),
      .a    (rs_val),
      .b    (rt_val),
      .hit  (cond_hit)
   );

   bnu_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
      .pc     (pc),
      .instr  (instr),
      .seq_pc (seq_pc),
      .rel_pc (rel_pc),
      .abs_pc (abs_pc)
   );

   logic              reg_ok;
   logic              d_taken, d_mis, d_lwe;
   logic [XLEN-1:0]   d_next;
   logic [RIDX_W-1:0] d_lreg;

   assign reg_ok = (rs_val[1:0] == 2'b00);

   always_comb begin
      d_taken = 1'b0;
      d_mis   = 1'b0;
      d_next  = seq_pc;
      unique case (dec.kind)
         K_REL: begin
            d_taken = cond_hit;
            if (cond_hit) d_next = rel_pc;
         end
         K_ABS: begin
            d_taken = 1'b1;
            d_next  = abs_pc;
         end
         K_REG: begin
            d_taken = reg_ok;
            d_mis   = ~reg_ok;
            if (reg_ok) d_next = rs_val;
         end
         default: d_taken = 1'b0;
      endcase
   end

   generate
      if (LINK_EN) begin : g_link
         assign d_lwe  = dec.link & ~d_mis;
         assign d_lreg = d_lwe ? (dec.link_rd ? instr[15:11] : RA_IDX)
                               : {RIDX_W{1'b0}};
      end else begin : g_nolink
         assign d_lwe  = 1'b0;
         assign d_lreg = {RIDX_W{1'b0}};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc   <= RESET_PC[XLEN-1:0];
         taken     <= 1'b0;
         link_we   <= 1'b0;
         link_reg  <= {RIDX_W{1'b0}};
         link_data <= {XLEN{1'b0}};
         misalign  <= 1'b0;
      end else begin
         next_pc   <= d_next;
         taken     <= d_taken;
         link_we   <= d_lwe;
         link_reg  <= d_lreg;
         link_data <= seq_pc;
         misalign  <= d_mis;
      end
   end
endmodule

// File: rtl/bnu_chk.sv
module bnu_chk #(
   parameter int XLEN   = 32,
   parameter int RIDX_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [XLEN-1:0]   pc,
   input logic [XLEN-1:0]   next_pc,
   input logic              taken,
   input logic              link_we,
   input logic [RIDX_W-1:0] link_reg,
   input logic [XLEN-1:0]   link_data,
   input logic              misalign
);
   logic primed;

   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R8
   mis_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> !taken);

   // R8
   mis_falls_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && misalign) |-> (next_pc == $past(pc) + XLEN'(4)) && !link_we);

   // R2
   seq_when_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !taken) |-> next_pc == $past(pc) + XLEN'(4));

   // R5
   link_return_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && link_we) |-> link_data == $past(pc) + XLEN'(4));

   // R9
   aligned_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(pc[1:0]) == 2'b00) |-> next_pc[1:0] == 2'b00);

   // R1
   idle_link_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_we |-> link_reg == '0);
endmodule

bind bnu_top bnu_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_bnu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc        (pc),
   .next_pc   (next_pc),
   .taken     (taken),
   .link_we   (link_we),
   .link_reg  (link_reg),
   .link_data (link_data),
   .misalign  (misalign)
);

// File: tb/test_bnu_top.sv
`timescale 1ns/1ps
module test_bnu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc = '0, instr = '0, rs_val = '0, rt_val = '0;
   logic [31:0] next_pc, link_data;
   logic        taken, link_we, misalign;
   logic [4:0]  link_reg;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   bnu_top i_bnu_top (
      .clk(clk), .rst_n(rst_n), .pc(pc), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .next_pc(next_pc), .taken(taken),
      .link_we(link_we), .link_reg(link_reg), .link_data(link_data),
      .misalign(misalign)
   );

   typedef struct packed {
      logic [31:0] npc;
      logic        tk;
      logic        lwe;
      logic [4:0]  lreg;
      logic        mis;
   } exp_t;

   function automatic exp_t model(input logic [31:0] p, input logic [31:0] i,
                                  input logic [31:0] a, input logic [31:0] b);
      exp_t e;
      logic [31:0] p4, br;
      logic c;
      p4 = p + 32'd4;
      br = p4 + {{14{i[15]}}, i[15:0], 2'b00};
      e = '0;
      e.npc = p4;
      c = 1'b0;
      case (i[31:26])
         6'd0: if (i[5:0] == 6'd8 || i[5:0] == 6'd9) begin
            if (a[1:0] != 2'b00) e.mis = 1'b1;
            else begin
               e.tk = 1'b1; e.npc = a;
               if (i[5:0] == 6'd9) begin e.lwe = 1'b1; e.lreg = i[15:11]; end
            end
         end
         6'd1: begin
            if (i[20:16] == 5'd0 || i[20:16] == 5'd16) c = $signed(a) < 0;
            if (i[20:16] == 5'd1 || i[20:16] == 5'd17) c = $signed(a) >= 0;
            if (c) begin e.tk = 1'b1; e.npc = br; end
            if (i[20:16] == 5'd16 || i[20:16] == 5'd17) begin
               e.lwe = 1'b1; e.lreg = 5'd31;
            end
         end
         6'd2, 6'd3: begin
            e.tk = 1'b1; e.npc = {p4[31:28], i[25:0], 2'b00};
            if (i[31:26] == 6'd3) begin e.lwe = 1'b1; e.lreg = 5'd31; end
         end
         6'd4, 6'd5, 6'd6, 6'd7: begin
            case (i[31:26])
               6'd4: c = (a == b);
               6'd5: c = (a != b);
               6'd6: c = $signed(a) <= 0;
               default: c = $signed(a) > 0;
            endcase
            if (c) begin e.tk = 1'b1; e.npc = br; end
         end
         default: ;
      endcase
      return e;
   endfunction

   task automatic check(input string req, input exp_t e, input logic [31:0] p);
      n_cmp++;
      if (next_pc !== e.npc || taken !== e.tk || link_we !== e.lwe ||
          misalign !== e.mis || link_reg !== e.lreg ||
          (e.lwe && link_data !== p + 32'd4)) begin
         n_bad++;
         $display("FAIL %s: got npc=%h tk=%b lwe=%b lreg=%0d ld=%h mis=%b exp npc=%h tk=%b lwe=%b lreg=%0d ld=%h mis=%b",
                  req, next_pc, taken, link_we, link_reg, link_data, misalign,
                  e.npc, e.tk, e.lwe, e.lreg, p + 32'd4, e.mis);
      end
   endtask

   task automatic run(input string req, input logic [31:0] p, input logic [31:0] i,
                      input logic [31:0] a, input logic [31:0] b);
      exp_t e;
      e = model(p, i, a, b);
      pc = p; instr = i; rs_val = a; rt_val = b;
      @(negedge clk);
      check(req, e, p);
   endtask

   function automatic logic [31:0] rnd_instr();
      logic [31:0] i;
      int k;
      i = $urandom;
      k = $urandom_range(0, 9);
      case (k)
         0: begin i[31:26] = 6'd0; i[5:0] = ($urandom_range(0, 1) != 0) ? 6'd8 : 6'd9; end
         1: begin i[31:26] = 6'd1;
                  i[20:16] = 5'($urandom_range(0, 3) == 0 ? 0 :
                              ($urandom_range(0, 1) != 0 ? 1 : (16 + $urandom_range(0, 1)))); end
         2: i[31:26] = 6'($urandom_range(2, 3));
         3, 4, 5, 6: i[31:26] = 6'($urandom_range(4, 7));
         7: begin i[31:26] = 6'd1; i[20:16] = 5'($urandom_range(2, 15)); end
         default: ;
      endcase
      return i;
   endfunction

   initial begin
      exp_t e;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset values
      e = '0; e.npc = 32'h0;
      check("R1", e, 32'h0);
      rst_n = 1'b1;

      // R2 sequential instructions
      run("R2", 32'h0000_1000, 32'h2000_0005, 32'h5, 32'h5);
      run("R2", 32'h0000_1000, {6'd1, 5'd3, 5'd2, 16'h0010}, 32'hFFFF_FFFF, 32'h0);
      // R3 equality
      run("R3", 32'h0040_0000, {6'd4, 5'd1, 5'd2, 16'hFFFF}, 32'h7, 32'h7);
      run("R3", 32'h0040_0000, {6'd4, 5'd1, 5'd2, 16'h0003}, 32'h7, 32'h8);
      run("R3", 32'h0040_0000, {6'd5, 5'd1, 5'd2, 16'h8000}, 32'h7, 32'h8);
      // R4 zero tests at the boundary
      run("R4", 32'h100, {6'd6, 5'd1, 5'd9, 16'h0004}, 32'h0, 32'h1);
      run("R4", 32'h100, {6'd7, 5'd1, 5'd9, 16'h0004}, 32'h0, 32'h0);
      run("R4", 32'h100, {6'd1, 5'd1, 5'd0, 16'h0004}, 32'h8000_0000, 32'h0);
      run("R4", 32'h100, {6'd1, 5'd1, 5'd1, 16'h0004}, 32'h0, 32'h0);
      // R5 link regardless of outcome
      run("R5", 32'h200, {6'd1, 5'd1, 5'd16, 16'h0008}, 32'h1, 32'h0);
      run("R5", 32'h200, {6'd1, 5'd1, 5'd17, 16'hFFF0}, 32'h1, 32'h0);
      // R6 region jumps, region taken from pc+4
      run("R6", 32'h1FFF_FFFC, {6'd2, 26'h3FF_FFFF}, 32'h0, 32'h0);
      run("R6", 32'hA000_0010, {6'd3, 26'h000_1234}, 32'h0, 32'h0);
      // R7 register jumps
      run("R7", 32'h300, {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd8}, 32'h8000_0040, 32'h0);
      run("R7", 32'h300, {6'd0, 5'd4, 5'd0, 5'd7, 5'd0, 6'd9}, 32'h0000_0800, 32'h0);
      // R8 misaligned register targets
      run("R8", 32'h300, {6'd0, 5'd4, 5'd0, 5'd7, 5'd0, 6'd9}, 32'h0000_0802, 32'h0);
      run("R8", 32'h300, {6'd0, 5'd4, 5'd0, 5'd0, 5'd0, 6'd8}, 32'h0000_0001, 32'h0);

      // R9: output holds until the next edge, then follows new inputs
      pc = 32'h400; instr = {6'd2, 26'h10}; rs_val = 0; rt_val = 0;
      @(negedge clk);
      e = model(32'h400, {6'd2, 26'h10}, 0, 0);
      pc = 32'h800; instr = 32'h0;
      #1;
      check("R9", e, 32'h400);
      @(negedge clk);
      check("R9", model(32'h800, 32'h0, 0, 0), 32'h800);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] p, i, a, b;
         p = {$urandom} & 32'hFFFF_FFFC;
         i = rnd_instr();
         a = $urandom;
         b = $urandom;
         case ($urandom_range(0, 5))
            0: b = a;
            1: a = 32'h0;
            2: a = 32'hFFFF_FFFF - 32'($urandom_range(0, 3));
            default: ;
         endcase
         run("R2-random", p, i, a, b);
      end

      // R1 again: reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      e = '0;
      check("R1", e, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule